// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial byte memory. It watches a serial clock line and an open-drain data line, both oversampled by the system clock. It recognises bus start and stop events and accepts a select byte, then a two-byte word address. It then either stores incoming data bytes into a page-organised byte array or returns stored bytes to the bus controller. Each byte it receives is acknowledged by pulling the data line low during the ninth clock.

A write ends with a stop event, which launches a self-timed programming interval. A counter of `WR_CYCLES` system clocks stands in for it. While that interval runs, the block ignores its own select byte. A standby flag is high whenever the bus is idle and no programming interval is pending.

The word address width is 14 or 15 bits. The implemented array may be smaller than the address space. The array is indexed by the low `IMPL_AW` address bits, so higher addresses alias onto it.

Top module: `eeprom2w_slave`

## Requirements
- R1: After reset the block releases the data line (`sda_oe_o` = 0) and holds `standby_o` = 1.
- R2: A data line fall while the clock is high is a start event and a rise is a stop event. A start at any point, including mid-transfer, returns the block to receiving a select byte.
- R3: The select byte is sent MSB first: a 7-bit address followed by a direction bit (1 = read). The block pulls the data line low on the ninth clock only when the address equals `DEV_ADDR`. Otherwise it acknowledges nothing until the next start.
- R4: The word address is two bytes, high byte first. Only the low `ADDR_W` bits are kept, and higher bits are ignored.
- R5: Each data byte of a write is acknowledged and stored. The low 6 address bits then increment and wrap inside the current 64-byte page, and the upper bits stay fixed.
- R6: A stop that follows at least one data byte starts a busy interval of `WR_CYCLES` clocks. During it, a matching select byte gets no acknowledge. A transfer that sends only an address does not start the interval.
- R7: Read data leaves MSB first and changes only after a clock fall. Each byte sent advances the address by one across the whole `ADDR_W`-bit space, wrapping to zero. A read that follows a start and select with no new address continues from the current address.
- R8: A controller NACK after a read byte makes the block release the data line and drive nothing until the next start.
- R9: `standby_o` is low from a start until the following stop, and for the whole busy interval after a write.
- R10: The array holds 2^`IMPL_AW` bytes, indexed by the low `IMPL_AW` bits of the word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Level seen on the data line |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| standby_o | output | 1 | Bus idle and no programming interval pending |

## Verification
The bench builds the block with a 15-bit word address, a 256-byte array and a 300-clock write interval. The short interval lets the bench attempt a select while the block is busy and measure when standby returns. With the 15-bit address, the bench can reach the last address 0x7FFF to test the sequential-read wrap. It can also set the top bit of the high address byte, which the block must discard. The 256-byte array lets the bench reach an aliased location above the array size within a few transfers.

// File: rtl/eeprom2w_pkg.sv
package eeprom2w_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_DEV,
      S_AHI,
      S_ALO,
      S_WDATA,
      S_RDATA,
      S_HOLD
   } tw_state_e;

   localparam int PG_AW = 6;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl_o,
   output logic sda_lvl_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [SYNC_N-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   if (SYNC_N < 2) begin : g_chk
      $error("tw_line_sync: SYNC_N must be at least 2");
   end

   for (genvar g = 0; g < SYNC_N; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_ff[0] <= 1'b1;
               sda_ff[0] <= 1'b1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
            end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_ff[g] <= 1'b1;
               sda_ff[g] <= 1'b1;
            end else begin
               scl_ff[g] <= scl_ff[g-1];
               sda_ff[g] <= sda_ff[g-1];
            end
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_ff[SYNC_N-1];
         sda_q <= sda_ff[SYNC_N-1];
      end

   assign scl_lvl_o  = scl_ff[SYNC_N-1];
   assign sda_lvl_o  = sda_ff[SYNC_N-1];
   assign scl_rise_o = scl_lvl_o & ~scl_q;
   assign scl_fall_o = ~scl_lvl_o & scl_q;
   assign start_o    = scl_lvl_o & scl_q & sda_q & ~sda_lvl_o;
   assign stop_o     = scl_lvl_o & scl_q & ~sda_q & sda_lvl_o;
endmodule

// File: rtl/tw_wr_timer.sv
module tw_wr_timer #(
   parameter int WR_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(WR_CYCLES + 1);
   logic [CW-1:0] cnt;

   if (WR_CYCLES < 1) begin : g_chk
      $error("tw_wr_timer: WR_CYCLES must be positive");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         cnt <= '0;
      else if (start_i)
         cnt <= CW'(WR_CYCLES);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;

   assign busy_o = (cnt != '0);

   AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> (cnt == $past(cnt) - 1'b1)); // R6
endmodule

// File: rtl/tw_byte_store.sv
module tw_byte_store #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);
   localparam int DEPTH = 1 << AW;
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk)
      if (we_i) cells[waddr_i] <= wdata_i;

   assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
   import eeprom2w_pkg::*;
#(
   parameter int         ADDR_W    = 14,
   parameter int         IMPL_AW   = 8,
   parameter logic [6:0] DEV_ADDR  = 7'h50,
   parameter int         WR_CYCLES = 250000,
   parameter int         SYNC_N    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o,
   output logic standby_o
);
   if (!(ADDR_W == 14 || ADDR_W == 15)) begin : g_chk_aw
      $error("eeprom2w_slave: ADDR_W must be 14 or 15");
   end
   if (IMPL_AW < PG_AW || IMPL_AW > ADDR_W) begin : g_chk_impl
      $error("eeprom2w_slave: IMPL_AW out of range");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, st_ev, sp_ev;
   logic tmr_busy, tmr_start, mem_we;
   logic [7:0] rdata;

   tw_state_e        st;
   logic [7:0]       sh, ahi, tx;
   logic [3:0]       bcnt;
   logic             ackph, mnack, wr_pend, oe_q;
   logic [ADDR_W-1:0] addr;
   logic [15:0]      full_a;
   logic [PG_AW-1:0] pg_nxt;

   tw_line_sync #(.SYNC_N(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(st_ev), .stop_o(sp_ev));

   tw_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .busy_o(tmr_busy));

   tw_byte_store #(.AW(IMPL_AW)) u_mem (
      .clk(clk), .we_i(mem_we), .waddr_i(addr[IMPL_AW-1:0]), .wdata_i(sh),
      .raddr_i(addr[IMPL_AW-1:0]), .rdata_o(rdata));

   assign full_a    = {ahi, sh};
   assign pg_nxt    = addr[PG_AW-1:0] + 1'b1;
   assign tmr_start = sp_ev & wr_pend;
   assign mem_we    = scl_fall & ~st_ev & ~sp_ev & (st == S_WDATA) & (bcnt == 4'd8) & ~ackph;
   assign sda_oe_o  = oe_q;
   assign standby_o = (st == S_IDLE) & ~tmr_busy;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st      <= S_IDLE;
         sh      <= '0;
         ahi     <= '0;
         tx      <= '0;
         bcnt    <= '0;
         ackph   <= 1'b0;
         mnack   <= 1'b0;
         wr_pend <= 1'b0;
         oe_q    <= 1'b0;
         addr    <= '0;
      end else if (st_ev) begin
         st    <= S_DEV;
         bcnt  <= '0;
         ackph <= 1'b0;
         oe_q  <= 1'b0;
      end else if (sp_ev) begin
         st      <= S_IDLE;
         bcnt    <= '0;
         ackph   <= 1'b0;
         oe_q    <= 1'b0;
         wr_pend <= 1'b0;
      end else begin
         if (scl_rise) begin
            if (ackph)
               mnack <= sda_lvl;
            else if (bcnt < 4'd8) begin
               sh   <= {sh[6:0], sda_lvl};
               bcnt <= bcnt + 1'b1;
            end
         end
         if (scl_fall) begin
            if (ackph) begin
               ackph <= 1'b0;
               bcnt  <= '0;
               oe_q  <= 1'b0;
               if (st == S_RDATA) begin
                  if (mnack)
                     st <= S_HOLD;
                  else begin
                     oe_q <= ~rdata[7];
                     tx   <= {rdata[6:0], 1'b0};
                     addr <= addr + 1'b1;
                  end
               end
            end else if (bcnt == 4'd8) begin
               ackph <= 1'b1;
               oe_q  <= 1'b0;
               case (st)
                  S_DEV:
                     if (sh[7:1] == DEV_ADDR && !tmr_busy) begin
                        oe_q  <= 1'b1;
                        mnack <= 1'b0;
                        st    <= sh[0] ? S_RDATA : S_AHI;
                     end else
                        st <= S_HOLD;
                  S_AHI: begin
                     oe_q <= 1'b1;
                     ahi  <= sh;
                     st   <= S_ALO;
                  end
                  S_ALO: begin
                     oe_q <= 1'b1;
                     addr <= full_a[ADDR_W-1:0];
                     st   <= S_WDATA;
                  end
                  S_WDATA: begin
                     oe_q    <= 1'b1;
                     wr_pend <= 1'b1;
                     addr    <= {addr[ADDR_W-1:PG_AW], pg_nxt};
                  end
                  default: oe_q <= 1'b0;
               endcase
            end else if (st == S_RDATA && bcnt != 4'd0) begin
               oe_q <= ~tx[7];
               tx   <= {tx[6:0], 1'b0};
            end
         end
      end

   AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_busy |-> !mem_we); // R6
   AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (addr[ADDR_W-1:PG_AW] == $past(addr[ADDR_W-1:PG_AW]))); // R5
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE || st == S_HOLD) && !ackph |-> !oe_q); // R8
   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) && !$past(st_ev) && !$past(sp_ev) |-> !scl_lvl); // R7
   AST_STANDBY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      st_ev |=> !standby_o); // R9
endmodule

// File: tb/eeprom2w_slave_tb.sv
module eeprom2w_slave_tb;
   localparam int H = 8;
   localparam int WRC = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus, sda_oe, standby;
   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign sda_bus = sda_m & ~sda_oe;

   eeprom2w_slave #(.ADDR_W(15), .IMPL_AW(8), .DEV_ADDR(7'h50),
                    .WR_CYCLES(WRC), .SYNC_N(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .standby_o(standby));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl = 1'b1; tk(H);
      sda_m = 1'b0; tk(H);
      scl = 1'b0; tk(2);
   endtask

   task automatic bus_rstart();
      tk(2); sda_m = 1'b1; tk(H);
      scl = 1'b1; tk(H);
      sda_m = 1'b0; tk(H);
      scl = 1'b0; tk(2);
   endtask

   task automatic bus_stop();
      tk(2); sda_m = 1'b0; tk(H);
      scl = 1'b1; tk(H);
      sda_m = 1'b1; tk(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         tk(2); sda_m = b[i]; tk(H - 2);
         scl = 1'b1; tk(H);
         scl = 1'b0;
      end
      tk(2); sda_m = 1'b1; tk(H - 2);
      scl = 1'b1; tk(H / 2);
      ack = !sda_bus;
      tk(H / 2); scl = 1'b0;
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] d);
      tk(2); sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tk(H);
         scl = 1'b1; tk(H / 2);
         d = {d[6:0], sda_bus};
         tk(H / 2); scl = 1'b0;
      end
      tk(2); sda_m = nack; tk(H - 2);
      scl = 1'b1; tk(H);
      scl = 1'b0;
   endtask

   task automatic wait_standby();
      for (int i = 0; i < 2000 && !standby; i++) tk(1);
   endtask

   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
      bit a;
      bus_start();
      send_byte(8'hA0, a); chk(a, "R3 select write", a, 1);
      send_byte(hi, a);    chk(a, {req, " addr hi"}, a, 1);
      send_byte(lo, a);    chk(a, {req, " addr lo"}, a, 1);
   endtask

   task automatic t_reset();
      chk(standby === 1'b1, "R1 standby after reset", standby, 1);
      chk(sda_oe === 1'b0, "R1 line released after reset", sda_oe, 0);
   endtask

   task automatic t_nomatch();
      bit a;
      bus_start();
      chk(standby === 1'b0, "R9 standby low after start", standby, 0);
      send_byte(8'hA4, a); chk(!a, "R3 foreign select not acked", a, 0);
      send_byte(8'h00, a); chk(!a, "R3 later byte ignored", a, 0);
      bus_stop(); tk(4);
      chk(standby === 1'b1, "R9 standby after stop", standby, 1);
   endtask

   task automatic t_page_write();
      bit a;
      int t0, t1;
      set_addr(8'h00, 8'h7E, "R4");
      send_byte(8'hA1, a); chk(a, "R5 data ack 0", a, 1);
      send_byte(8'hB2, a); chk(a, "R5 data ack 1", a, 1);
      send_byte(8'hC3, a); chk(a, "R5 data ack 2", a, 1);
      send_byte(8'hD4, a); chk(a, "R5 data ack 3", a, 1);
      bus_stop();
      t0 = cyc;
      tk(5);
      chk(standby === 1'b0, "R9 standby low during write cycle", standby, 0);
      bus_start();
      send_byte(8'hA0, a); chk(!a, "R6 select refused while busy", a, 0);
      bus_stop();
      wait_standby();
      t1 = cyc;
      chk((t1 - t0) >= WRC - 15 && (t1 - t0) <= WRC + 5, "R6 write cycle length", t1 - t0, WRC);
   endtask

   task automatic t_seq_read();
      bit a;
      logic [7:0] d;
      set_addr(8'h00, 8'h7E, "R4");
      bus_rstart();
      send_byte(8'hA1, a); chk(a, "R2 select after repeated start", a, 1);
      recv_byte(1'b0, d); chk(d === 8'hA1, "R7 read byte 0", d, 8'hA1);
      recv_byte(1'b1, d); chk(d === 8'hB2, "R7 read byte 1", d, 8'hB2);
      for (int i = 0; i < 6; i++) begin
         tk(1);
         chk(sda_oe === 1'b0, "R8 line released after NACK", sda_oe, 0);
      end
      bus_stop(); tk(4);
      chk(standby === 1'b1, "R6 address-only write starts no cycle", standby, 1);
   endtask

   task automatic t_wrap_current();
      bit a;
      logic [7:0] d;
      set_addr(8'h00, 8'h40, "R4");
      bus_rstart();
      send_byte(8'hA1, a);
      recv_byte(1'b1, d); chk(d === 8'hC3, "R5 in-page wrap stored", d, 8'hC3);
      bus_stop();
      bus_start();
      send_byte(8'hA1, a); chk(a, "R7 current read select", a, 1);
      recv_byte(1'b1, d); chk(d === 8'hD4, "R7 current address read", d, 8'hD4);
      bus_stop(); tk(4);
   endtask

   task automatic t_space_wrap();
      bit a;
      logic [7:0] d;
      set_addr(8'h7F, 8'hFF, "R4");
      send_byte(8'hE2, a);
      bus_stop(); wait_standby();
      set_addr(8'h80, 8'h00, "R4");
      send_byte(8'hF0, a);
      bus_stop(); wait_standby();
      set_addr(8'h7F, 8'hFF, "R4");
      bus_rstart();
      send_byte(8'hA1, a);
      recv_byte(1'b0, d); chk(d === 8'hE2, "R7 last address", d, 8'hE2);
      recv_byte(1'b1, d); chk(d === 8'hF0, "R4 R7 wrap to zero, top bit dropped", d, 8'hF0);
      bus_stop();
      set_addr(8'h01, 8'h00, "R4");
      bus_rstart();
      send_byte(8'hA1, a);
      recv_byte(1'b1, d); chk(d === 8'hF0, "R10 aliased location", d, 8'hF0);
      bus_stop(); tk(4);
   endtask

   initial begin
      tk(5);
      rst_n = 1'b1;
      tk(5);
      t_reset();
      t_nomatch();
      t_page_write();
      t_seq_read();
      t_wrap_current();
      t_space_wrap();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule